// File: doc/BRIEF.md
# Multi-Source Watchdog Timer with Tap-Selected Prescaler

This block guards a small microcontroller against runaway code. It counts ticks from one of three sources. The first is a low-speed crystal tick, the second is the system clock divided by four, and the third is an internal low-speed RC tick. The ticks pass through a binary prescaler, and a tap multiplexer decides which prescaler stage advances an overflow counter. When that counter wraps, the watchdog has expired. The block then sets a sticky expiry flag and asks the rest of the chip to act.

The action depends on the core's state. A running core receives a full device reset request. A halted core instead receives a wake-up and a partial reset, which covers only the program counter and stack pointer. Three events restart the count: a low level on the external reset pin, a clear-watchdog instruction strobe and a halt instruction strobe. Any change to the source or tap selection also restarts the count, so that reprogramming cannot cause a false expiry. All logic runs on the single system clock, and the slow sources arrive as one-cycle enable pulses in that domain.

Top module: `wdt_top`

## Requirements
- R1: `src_sel` picks the counted source as follows: 00 selects `xtal_tick`, 01 selects the internal system-clock/4 tick and 10 selects `rc_tick`. The value 11 selects no source, and the count then holds.
- R2: The system-clock/4 tick fires once every four `clk` cycles while `halted` is low. While `halted` is high it does not fire and its phase is frozen, so this source never expires during halt.
- R3: After a restart, expiry occurs on the (256 × 2^`div_sel`)-th tick of the selected source. A `div_sel` of 000 gives 256 ticks, and 111 gives the longest period of 32768 ticks. The count then resumes from zero.
- R4: An expiry while `halted` is low drives `rst_req` high for exactly one cycle, in the cycle after the expiring tick is sampled. It also sets `to_flag`.
- R5: An expiry while `halted` is high drives `wake_req` and `part_rst` high together for one cycle and sets `to_flag`. It leaves `rst_req` low.
- R6: `to_flag` stays set until `rst_n` is asserted or `clr_wdt` is sampled high. No other input clears it.
- R7: Sampling `ext_rst_n` low, `clr_wdt` high or `halt_cmd` high restarts the count from zero, including the divide-by-four phase. No tick counts in that cycle.
- R8: A change of `src_sel` or `div_sel` from the previous cycle's value restarts the count in the same way as R7.
- R9: While `rst_n` is low and right after it is released, `to_flag`, `rst_req`, `wake_req` and `part_rst` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin level, low restarts the count |
| src_sel | input | 2 | Tick source select |
| div_sel | input | 3 | Prescaler tap select, ratio 2^div_sel |
| xtal_tick | input | 1 | Low-speed crystal tick enable |
| rc_tick | input | 1 | Internal low-speed RC tick enable |
| halted | input | 1 | Core is in halt mode |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| halt_cmd | input | 1 | Halt instruction strobe |
| to_flag | output | 1 | Sticky expiry status |
| rst_req | output | 1 | One-cycle full device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| part_rst | output | 1 | One-cycle partial reset (program counter, stack pointer) |

## Verification
The bench targets the following corner cases:
- The longest tap. A design with an off-by-one tap index would expire at 16384 or 65536 ticks.
- The divide-by-four source during halt. A design that failed to freeze it would wake the core from its own stopped clock.
- A halt-mode expiry. A design that reused the run-mode path would assert a full reset.
- A change of the tap selection halfway through a count. A design that kept the old count would expire early.

The bench also checks that each clear strobe, applied just before expiry, postpones the reset, and that `to_flag` survives everything except the clear instruction and power-on reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      SRC_XTAL   = 2'b00,
      SRC_SYSDIV = 2'b01,
      SRC_RC     = 2'b10,
      SRC_NONE   = 2'b11
   } wdt_src_e;
endpackage

// File: rtl/wdt_src_mux.sv
module wdt_src_mux
   import wdt_pkg::*;
#(
   parameter int SYS_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       halted,
   input  logic [1:0] src_sel,
   input  logic       xtal_tick,
   input  logic       rc_tick,
   output logic       src_tick
);
   localparam int DW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;

   logic sys_tick;

   generate
      if (SYS_DIV == 1) begin : g_nodiv
         assign sys_tick = !halted;
      end else begin : g_div
         logic [DW-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           phase_q <= '0;
            else if (clr)         phase_q <= '0;
            else if (!halted)     phase_q <= phase_q + 1'b1;
         end
         assign sys_tick = !halted && (&phase_q);

         // the divided tick must be spaced by the full division ratio
         AST_SYS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            sys_tick |=> !sys_tick); // R2
      end
   endgenerate

   always_comb begin
      unique case (wdt_src_e'(src_sel))
         SRC_XTAL:   src_tick = xtal_tick;
         SRC_SYSDIV: src_tick = sys_tick;
         SRC_RC:     src_tick = rc_tick;
         default:    src_tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRE_W = 7,
   localparam int SEL_W = $clog2(PRE_W + 1),
   localparam int NTAP  = 2 ** SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick_in,
   input  logic [SEL_W-1:0] tap_sel,
   output logic             tap_tick
);
   logic [PRE_W-1:0] pre_q;
   logic [NTAP-1:0]  taps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (clr)     pre_q <= '0;
      else if (tick_in) pre_q <= pre_q + 1'b1;
   end

   generate
      for (genvar n = 0; n < NTAP; n++) begin : g_tap
         if (n == 0) begin : g_t0
            assign taps[n] = tick_in;
         end else if (n <= PRE_W) begin : g_tn
            assign taps[n] = tick_in && (&pre_q[n-1:0]);
         end else begin : g_tz
            assign taps[n] = 1'b0;
         end
      end
   endgenerate

   assign tap_tick = taps[tap_sel];

   // prescaler holds when neither a tick nor a clear is present
   AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick_in) |=> $stable(pre_q)); // R7
   // a tap pulse can only appear on a source tick
   AST_TAP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      tap_tick |-> tick_in); // R3
endmodule

// File: rtl/wdt_ovf_ctr.sv
module wdt_ovf_ctr #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic ovf
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
   end

   assign ovf = step && !clr && (&cnt_q);

   // after an overflow the counter restarts from zero
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/wdt_top.sv
module wdt_top
   import wdt_pkg::*;
#(
   parameter int PRE_W   = 7,
   parameter int CNT_W   = 8,
   parameter int SYS_DIV = 4,
   localparam int SEL_W  = $clog2(PRE_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst_n,
   input  logic [1:0]       src_sel,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             xtal_tick,
   input  logic             rc_tick,
   input  logic             halted,
   input  logic             clr_wdt,
   input  logic             halt_cmd,
   output logic             to_flag,
   output logic             rst_req,
   output logic             wake_req,
   output logic             part_rst
);
   generate
      if (PRE_W < 1) begin : g_bad_pre
         $error("PRE_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (SYS_DIV < 1 || (SYS_DIV & (SYS_DIV - 1)) != 0) begin : g_bad_div
         $error("SYS_DIV must be a power of two");
      end
   endgenerate

   localparam int CFG_W = 2 + SEL_W;

   logic [CFG_W-1:0] cfg_q;
   logic             cfg_chg;
   logic             clr;
   logic             src_tick;
   logic             tap_tick;
   logic             expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= {src_sel, div_sel};
   end

   assign cfg_chg = ({src_sel, div_sel} != cfg_q);
   assign clr     = !ext_rst_n || clr_wdt || halt_cmd || cfg_chg;

   wdt_src_mux #(.SYS_DIV(SYS_DIV)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .halted    (halted),
      .src_sel   (src_sel),
      .xtal_tick (xtal_tick),
      .rc_tick   (rc_tick),
      .src_tick  (src_tick)
   );

   wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .tick_in  (src_tick),
      .tap_sel  (div_sel),
      .tap_tick (tap_tick)
   );

   wdt_ovf_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (tap_tick),
      .ovf   (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_flag  <= 1'b0;
         rst_req  <= 1'b0;
         wake_req <= 1'b0;
         part_rst <= 1'b0;
      end else begin
         rst_req  <= expire && !halted;
         wake_req <= expire && halted;
         part_rst <= expire && halted;
         if (clr_wdt)     to_flag <= 1'b0;
         else if (expire) to_flag <= 1'b1;
      end
   end

   AST_RUN_ONLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(!halted)); // R4
   AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R4
   AST_WAKE_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($past(halted) && !rst_req)); // R5
   AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || wake_req) |-> to_flag); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !clr_wdt) |=> to_flag); // R6
   AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !(rst_req || wake_req)); // R7
endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_rst_n = 1'b1;
   logic [1:0] src_sel = 2'b00;
   logic [2:0] div_sel = 3'b000;
   logic       xtal_tick = 1'b0;
   logic       rc_tick = 1'b0;
   logic       halted = 1'b0;
   logic       clr_wdt = 1'b0;
   logic       halt_cmd = 1'b0;
   logic       to_flag, rst_req, wake_req, part_rst;

   int errors = 0;
   int checks = 0;
   int xtal_per = 1;
   int rc_per = 3;
   int n_rst = 0;
   int n_wake = 0;
   bit cmp_on = 1'b0;
   string tag = "R9";

   // behavioural reference state
   int  m_cnt, m_ph, m_src, m_ws;
   bit  e_to, e_rst, e_wake;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_top u_dut (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .src_sel(src_sel),
      .div_sel(div_sel), .xtal_tick(xtal_tick), .rc_tick(rc_tick),
      .halted(halted), .clr_wdt(clr_wdt), .halt_cmd(halt_cmd),
      .to_flag(to_flag), .rst_req(rst_req), .wake_req(wake_req),
      .part_rst(part_rst)
   );

   // tick generators, driven away from the active edge
   initial begin
      int cx = 0;
      int cr = 0;
      forever begin
         @(negedge clk);
         cx++; cr++;
         xtal_tick = (cx >= xtal_per);
         if (cx >= xtal_per) cx = 0;
         rc_tick = (cr >= rc_per);
         if (cr >= rc_per) cr = 0;
      end
   end

   // reference model: count ticks since last restart
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_ph = 0; m_src = 0; m_ws = 0;
         e_to = 0; e_rst = 0; e_wake = 0;
      end else begin
         bit clr;
         bit tk;
         clr = !ext_rst_n || clr_wdt || halt_cmd ||
               (int'(src_sel) != m_src) || (int'(div_sel) != m_ws);
         m_src = int'(src_sel);
         m_ws  = int'(div_sel);
         e_rst = 0; e_wake = 0;
         if (clr) begin
            m_cnt = 0; m_ph = 0;
         end else begin
            tk = 0;
            case (m_src)
               0: tk = xtal_tick;
               1: tk = !halted && (m_ph == 3);
               2: tk = rc_tick;
               default: tk = 0;
            endcase
            if (!halted) m_ph = (m_ph + 1) % 4;
            if (tk) begin
               m_cnt++;
               if (m_cnt == (256 << m_ws)) begin
                  m_cnt = 0;
                  e_to = 1;
                  if (halted) e_wake = 1; else e_rst = 1;
               end
            end
         end
         if (clr_wdt) e_to = 0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         check(to_flag == e_to, tag, "to_flag", int'(to_flag), int'(e_to));
         check(rst_req == e_rst, tag, "rst_req", int'(rst_req), int'(e_rst));
         check(wake_req == e_wake, tag, "wake_req", int'(wake_req), int'(e_wake));
         check(part_rst == e_wake, tag, "part_rst", int'(part_rst), int'(e_wake));
         if (rst_req) n_rst++;
         if (wake_req) n_wake++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clr(input int which);
      @(negedge clk);
      case (which)
         0: ext_rst_n = 1'b0;
         1: clr_wdt = 1'b1;
         default: halt_cmd = 1'b1;
      endcase
      @(negedge clk);
      ext_rst_n = 1'b1; clr_wdt = 1'b0; halt_cmd = 1'b0;
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: bench hung, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int base;
      cyc(3);
      check({to_flag, rst_req, wake_req, part_rst} == 4'b0, "R9", "outputs in reset",
            int'({to_flag, rst_req, wake_req, part_rst}), 0);
      @(negedge clk); rst_n = 1'b1;
      cmp_on = 1'b1;
      cyc(2);

      // R4, R3: crystal every cycle, shortest tap
      tag = "R4"; base = n_rst;
      cyc(300);
      check(n_rst - base == 1, "R4", "run-mode resets in 300 cycles", n_rst - base, 1);
      check(to_flag == 1'b1, "R6", "flag after expiry", int'(to_flag), 1);

      // R6: flag survives ext reset and halt strobe
      tag = "R6";
      pulse_clr(0); pulse_clr(2); cyc(2);
      check(to_flag == 1'b1, "R6", "flag kept by other clears", int'(to_flag), 1);
      pulse_clr(1); cyc(1);
      check(to_flag == 1'b0, "R6", "flag cleared by clr_wdt", int'(to_flag), 0);

      // R3: longest tap
      tag = "R3"; div_sel = 3'b111; base = n_rst;
      cyc(32780);
      check(n_rst - base == 1, "R3", "one expiry at 1:128", n_rst - base, 1);

      // R2: divided system clock, tap 0 -> 1024 cycles
      tag = "R2"; div_sel = 3'b000; src_sel = 2'b01; base = n_rst;
      cyc(1030);
      check(n_rst - base == 1, "R2", "sysdiv expiry", n_rst - base, 1);

      // R1: RC source every 3 cycles, tap 1 -> 1536 cycles; then no source
      tag = "R1"; src_sel = 2'b10; div_sel = 3'b001; base = n_rst;
      cyc(1545);
      check(n_rst - base == 1, "R1", "rc source expiry", n_rst - base, 1);
      src_sel = 2'b11; base = n_rst;
      cyc(1000);
      check(n_rst - base == 0, "R1", "no source no expiry", n_rst - base, 0);

      // R7: each clear kind keeps pushing the expiry back
      tag = "R7"; src_sel = 2'b00; div_sel = 3'b000; base = n_rst;
      for (int k = 0; k < 6; k++) begin
         cyc(240);
         pulse_clr(k % 3);
      end
      check(n_rst - base == 0, "R7", "clears postpone expiry", n_rst - base, 0);

      // R8: tap change mid count restarts
      tag = "R8"; base = n_rst;
      cyc(200); div_sel = 3'b001;
      cyc(400);
      check(n_rst - base == 0, "R8", "no early expiry after tap change", n_rst - base, 0);
      cyc(150);
      check(n_rst - base == 1, "R8", "expiry 512 after change", n_rst - base, 1);

      // R5: halted with crystal source wakes
      tag = "R5"; pulse_clr(1); div_sel = 3'b000; halted = 1'b1;
      base = n_rst;
      cyc(300);
      check(n_wake == 1, "R5", "wake in halt", n_wake, 1);
      check(n_rst - base == 0, "R5", "no full reset in halt", n_rst - base, 0);

      // R2: sysdiv frozen in halt
      tag = "R2"; src_sel = 2'b01; base = n_wake;
      cyc(2000);
      check(n_wake - base == 0, "R2", "sysdiv stopped in halt", n_wake - base, 0);
      halted = 1'b0;
      cyc(4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule